// File: doc/BRIEF.md
# Dual Interval Timer Unit

This block holds two 16-bit down-counters behind a byte-wide register bus. The first timer has its own 16-bit reload latch. It runs either once per load or continuously, reloading from the latch on every timeout. In either mode it can drive a port output pin as a single timeout edge or as a square wave. The second timer is one-shot only. It counts either core clocks or falling edges on an external pulse pin. The pulse pin passes through a two-stage synchroniser before edge detection.

Software loads a timer in two steps. It first writes the low byte, which goes to a holding latch. It then writes the high byte, and that write starts the count. Each timer raises a timeout flag. Software clears the flag by reading that timer's low counter byte or by loading the timer again. The mode bits come from an auxiliary control register that lives outside this block. The flags go to an interrupt controller that lives elsewhere.

Top module: `dit_top`

## Requirements
- R1: After reset, both counters, the reload latch and both flags are zero, and the timer 1 output pin `t1_pin` is high.
- R2: A write to address 4 or address 6 changes only the low byte of the timer 1 latch. A write to address 7 changes only the high byte of the latch. None of these writes changes the running timer 1 counter.
- R3: A write to address 5 stores the high byte into the latch, copies the full latch into the timer 1 counter, and clears the timer 1 flag. In one-shot mode with output enabled, it also drives `t1_pin` low.
- R4: A loaded nonzero count N decrements by one on every clock. The timer 1 flag rises on the Nth clock edge after the load, which is the edge on which the count passes from 1 to 0.
- R5: In one-shot mode, a counter that has reached zero stays at zero, and once its flag is cleared, no further flag is raised until the next load.
- R6: In free-running mode (`aux_mode[1]`=1), timer 1 reloads from the latch at each timeout and sets its flag, so a latch value L gives one timeout every L clocks.
- R7: `aux_mode[2]`=1 enables the pin output. In free-running mode, each timeout inverts `t1_pin`. In one-shot mode, `t1_pin` is low while counting and goes high at the timeout. When `aux_mode[2]`=0, `t1_pin` does not change.
- R8: A read strobe at address 4 clears the timer 1 flag, and a read strobe at address 8 clears the timer 2 flag. A read of any other address leaves both flags unchanged.
- R9: A write to address 8 stores the timer 2 low latch. A write to address 9 loads the timer 2 counter with {written byte, low latch} and clears the timer 2 flag. With `aux_mode[0]`=0, timer 2 counts clocks once and then holds at zero.
- R10: With `aux_mode[0]`=1, timer 2 decrements only on a falling edge of `pulse_in`. Each decrement lands on the third clock edge after the low level is first sampled.
- R11: Read data is combinational. Addresses 4 and 5 return timer 1 counter low and high, 6 and 7 return latch low and high, and 8 and 9 return timer 2 counter low and high. Any other address returns 0, and `rdata` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (also side-effect clear) |
| rdata | output | 8 | Read data |
| aux_mode | input | 3 | [2] pin output enable, [1] timer 1 free-run, [0] timer 2 pulse counting |
| pulse_in | input | 1 | External pulse pin for timer 2 |
| t1_pin | output | 1 | Timer 1 port output bit |
| t1_flag | output | 1 | Timer 1 timeout flag |
| t2_flag | output | 1 | Timer 2 timeout flag |

## Verification
The bench sweeps one-shot loads from 1 to 10 and free-run periods from 2 to 6, and checks the flag and the pin on every cycle. A design that is off by one on the timeout edge, or that reloads with an extra idle cycle, fails at the first boundary. The bench reads the counter after a latch-low write. A design that writes low bytes straight into the counter shows a corrupted count there. The bench also leaves a timer sitting at zero after its flag is cleared. A design that fires again would raise the flag a second time. In pulse mode, the bench reads the count one cycle before the decrement is due. A synchroniser of the wrong depth, or edge detection on rising edges, shows up there as an early, late or missing decrement.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_T1_LO  = 4'h4;
  localparam logic [ADDR_W-1:0] A_T1_HI  = 4'h5;
  localparam logic [ADDR_W-1:0] A_T1L_LO = 4'h6;
  localparam logic [ADDR_W-1:0] A_T1L_HI = 4'h7;
  localparam logic [ADDR_W-1:0] A_T2_LO  = 4'h8;
  localparam logic [ADDR_W-1:0] A_T2_HI  = 4'h9;

  typedef struct packed {
    logic pin_en;
    logic free_run;
    logic t2_pulses;
  } aux_mode_t;
endpackage

// File: rtl/dit_t1.sv
module dit_t1 #(
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lo_wr,
  input  logic            hi_latch_wr,
  input  logic            load,
  input  logic [BW-1:0]   wdata,
  input  logic            rd_clr,
  input  logic            free_run,
  input  logic            pin_en,
  output logic [2*BW-1:0] cnt,
  output logic [2*BW-1:0] latch,
  output logic            flag,
  output logic            wave,
  output logic            hit
);
  localparam int CW = 2 * BW;

  function automatic logic [CW-1:0] dec1(input logic [CW-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  logic [CW-1:0] load_val;
  assign load_val = {wdata, latch[BW-1:0]};
  assign hit      = !load && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      latch <= '0;
      flag  <= 1'b0;
      wave  <= 1'b1;
    end else if (load) begin
      latch[CW-1:BW] <= wdata;
      cnt            <= load_val;
      flag           <= 1'b0;
      if (pin_en && !free_run) wave <= 1'b0;
    end else begin
      if (lo_wr)       latch[BW-1:0]  <= wdata;
      if (hi_latch_wr) latch[CW-1:BW] <= wdata;
      if (hit) begin
        flag <= 1'b1;
        cnt  <= free_run ? latch : '0;
        if (pin_en) wave <= free_run ? ~wave : 1'b1;
      end else begin
        cnt <= dec1(cnt);
        if (rd_clr) flag <= 1'b0;
      end
    end
  end

  // R3
  load_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!flag && cnt == $past(load_val)));
  // R4
  hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  // R4
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt > CW'(1)) |=> (cnt == $past(cnt) - 1'b1));
  // R5
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_run && !load && cnt == '0) |=> (cnt == '0));
  // R7
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && free_run && pin_en) |=> (wave != $past(wave)));
endmodule

// File: rtl/dit_t2.sv
module dit_t2 #(
  parameter int BW   = 8,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pulse_in,
  input  logic            pulse_mode,
  input  logic            lo_wr,
  input  logic            load,
  input  logic [BW-1:0]   wdata,
  input  logic            rd_clr,
  output logic [2*BW-1:0] cnt,
  output logic            flag,
  output logic            step,
  output logic            hit
);
  localparam int CW = 2 * BW;

  function automatic logic [CW-1:0] dec_if(input logic [CW-1:0] v, input logic en);
    return (en && v != '0) ? v - 1'b1 : v;
  endfunction

  logic [BW-1:0] lo_latch;
  logic [SYNC:0] sh;
  logic          fall;

  assign fall = sh[SYNC] & ~sh[SYNC-1];
  assign step = pulse_mode ? fall : 1'b1;
  assign hit  = !load && step && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-1:0], pulse_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      lo_latch <= '0;
      flag     <= 1'b0;
    end else if (load) begin
      cnt  <= {wdata, lo_latch};
      flag <= 1'b0;
    end else begin
      if (lo_wr) lo_latch <= wdata;
      cnt <= dec_if(cnt, step);
      if (hit)         flag <= 1'b1;
      else if (rd_clr) flag <= 1'b0;
    end
  end

  // R10
  no_step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cnt));
  // R9
  t2_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  // R9
  t2_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !flag);
endmodule

// File: rtl/dit_top.sv
module dit_top
  import dit_pkg::*;
#(
  parameter int BW   = 8,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BW-1:0]     wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [BW-1:0]     rdata,
  input  logic [2:0]        aux_mode,
  input  logic              pulse_in,
  output logic              t1_pin,
  output logic              t1_flag,
  output logic              t2_flag
);
  localparam int CW = 2 * BW;

  aux_mode_t     mode;
  logic [CW-1:0] t1_cnt, t1_latch, t2_cnt;
  logic          t1_hit, t2_hit, t2_step;
  logic [BW-1:0] rmux;

  assign mode = aux_mode_t'(aux_mode);

  dit_t1 #(.BW(BW)) u_t1 (
    .clk(clk), .rst_n(rst_n),
    .lo_wr(wr_en && (addr == A_T1_LO || addr == A_T1L_LO)),
    .hi_latch_wr(wr_en && addr == A_T1L_HI),
    .load(wr_en && addr == A_T1_HI),
    .wdata(wdata),
    .rd_clr(rd_en && addr == A_T1_LO),
    .free_run(mode.free_run), .pin_en(mode.pin_en),
    .cnt(t1_cnt), .latch(t1_latch), .flag(t1_flag),
    .wave(t1_pin), .hit(t1_hit)
  );

  dit_t2 #(.BW(BW), .SYNC(SYNC)) u_t2 (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in),
    .pulse_mode(mode.t2_pulses),
    .lo_wr(wr_en && addr == A_T2_LO),
    .load(wr_en && addr == A_T2_HI),
    .wdata(wdata),
    .rd_clr(rd_en && addr == A_T2_LO),
    .cnt(t2_cnt), .flag(t2_flag), .step(t2_step), .hit(t2_hit)
  );

  always_comb begin
    case (addr)
      A_T1_LO:  rmux = t1_cnt[BW-1:0];
      A_T1_HI:  rmux = t1_cnt[CW-1:BW];
      A_T1L_LO: rmux = t1_latch[BW-1:0];
      A_T1L_HI: rmux = t1_latch[CW-1:BW];
      A_T2_LO:  rmux = t2_cnt[BW-1:0];
      A_T2_HI:  rmux = t2_cnt[CW-1:BW];
      default:  rmux = '0;
    endcase
  end
  assign rdata = rd_en ? rmux : '0;

  // R8
  rd_other_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != A_T1_LO && !wr_en && !t1_hit && t1_flag) |=> t1_flag);
  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));
endmodule

// File: tb/tb_dit_top.sv
module tb_dit_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rdata;
  logic [2:0] aux_mode = '0;
  logic       pulse_in = 1'b1;
  logic       t1_pin, t1_flag, t2_flag;
  int checks = 0, errors = 0;

  dit_top dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .aux_mode(aux_mode), .pulse_in(pulse_in),
    .t1_pin(t1_pin), .t1_flag(t1_flag), .t2_flag(t2_flag));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic w0;
    step(3);
    rst_n = 1'b1;
    // R1 reset state
    chk(t1_flag == 0 && t2_flag == 0, "R1 flags", {t1_flag, t2_flag}, 0);
    chk(t1_pin == 1, "R1 pin", t1_pin, 1);
    rd(4'h5, v); chk(v == 0, "R1 t1 hi", v, 0);
    rd(4'h6, v); chk(v == 0, "R1 latch lo", v, 0);
    rd(4'h9, v); chk(v == 0, "R1 t2 hi", v, 0);

    // R3 R4 R7 R5: one-shot with pin output, sweep of load values
    aux_mode = 3'b100;
    for (int n = 1; n <= 10; n++) begin
      wr(4'h6, 8'(n)); wr(4'h5, 8'h00);
      chk(t1_flag == 0, "R3 flag cleared by load", t1_flag, 0);
      chk(t1_pin == 0, "R3 pin low on load", t1_pin, 0);
      for (int j = 1; j <= n + 3; j++) begin
        step(1);
        chk(t1_flag == (j >= n), "R4 timeout edge", t1_flag, int'(j >= n));
        chk(t1_pin == (j >= n), "R7 one-shot pin", t1_pin, int'(j >= n));
      end
      rd(4'h4, v); chk(v == 0, "R5 count held at zero", v, 0);
      step(4);
      chk(t1_flag == 0, "R5 no second flag", t1_flag, 0);
    end

    // R11 R4: byte readback of a two-byte count
    aux_mode = 3'b000;
    wr(4'h6, 8'h03); wr(4'h5, 8'h02);
    rd(4'h5, v); chk(v == 8'h02, "R11 t1 hi", v, 2);
    rd(4'h4, v); chk(v == 8'h02, "R4 t1 lo after one clock", v, 2);
    rd(4'h7, v); chk(v == 8'h02, "R11 latch hi", v, 2);
    rd(4'h6, v); chk(v == 8'h03, "R11 latch lo", v, 3);
    rd(4'hA, v); chk(v == 0, "R11 unmapped", v, 0);
    #1 chk(rdata == 0, "R11 idle rdata", rdata, 0);

    // R2: latch writes leave the running counter alone
    wr(4'h6, 8'd20); wr(4'h5, 8'h00);
    wr(4'h4, 8'h55);
    rd(4'h6, v); chk(v == 8'h55, "R2 latch lo via addr4", v, 8'h55);
    rd(4'h4, v); chk(v == 8'd18, "R2 counter untouched", v, 18);
    wr(4'h7, 8'h66);
    rd(4'h5, v); chk(v == 8'h00, "R2 addr7 counter hi", v, 0);
    rd(4'h7, v); chk(v == 8'h66, "R2 addr7 latch hi", v, 8'h66);

    // R6 R7: free-run with pin, sweep of periods
    aux_mode = 3'b110;
    for (int l = 2; l <= 6; l++) begin
      wr(4'h6, 8'(l)); wr(4'h5, 8'h00);
      w0 = t1_pin;
      for (int j = 1; j <= 3 * l + 1; j++) begin
        step(1);
        chk(t1_flag == (j >= l), "R6 free-run flag", t1_flag, int'(j >= l));
        chk(t1_pin == (w0 ^ ((j / l) % 2 == 1)), "R7 toggle", t1_pin,
            int'(w0 ^ ((j / l) % 2 == 1)));
      end
    end

    // R7 pin disabled
    aux_mode = 3'b010;
    wr(4'h6, 8'd3); wr(4'h5, 8'h00);
    w0 = t1_pin;
    step(10);
    chk(t1_pin == w0, "R7 pin unchanged when disabled", t1_pin, w0);
    chk(t1_flag == 1, "R6 flag with pin disabled", t1_flag, 1);

    // R8: only the low counter read clears
    wr(4'h6, 8'd40); wr(4'h5, 8'h00);
    step(40);
    chk(t1_flag == 1, "R6 long period", t1_flag, 1);
    rd(4'h5, v); chk(t1_flag == 1, "R8 other read keeps flag", t1_flag, 1);
    rd(4'h4, v); chk(t1_flag == 0, "R8 addr4 read clears", t1_flag, 0);

    // R9: timer 2 counting clocks
    aux_mode = 3'b000;
    for (int n = 1; n <= 6; n++) begin
      wr(4'h8, 8'(n)); wr(4'h9, 8'h00);
      chk(t2_flag == 0, "R9 load clears", t2_flag, 0);
      for (int j = 1; j <= n + 2; j++) begin
        step(1);
        chk(t2_flag == (j >= n), "R9 t2 timeout", t2_flag, int'(j >= n));
      end
      rd(4'h9, v); chk(t2_flag == 1, "R8 t2 hi read keeps flag", t2_flag, 1);
      rd(4'h8, v); chk(v == 0 && t2_flag == 0, "R8 t2 addr8 read clears", v, 0);
      step(5);
      chk(t2_flag == 0, "R9 one-shot no refire", t2_flag, 0);
    end
    wr(4'h8, 8'h05); wr(4'h9, 8'h01);
    rd(4'h9, v); chk(v == 8'h01, "R9 t2 hi", v, 1);
    rd(4'h8, v); chk(v == 8'h04, "R9 t2 lo", v, 4);

    // R10: timer 2 counting falling edges
    aux_mode = 3'b001;
    pulse_in = 1'b1;
    step(4);
    wr(4'h8, 8'd3); wr(4'h9, 8'h00);
    step(10);
    rd(4'h8, v); chk(v == 3, "R10 no edges no count", v, 3);
    for (int p = 1; p <= 3; p++) begin
      pulse_in = 1'b0;
      step(2);
      rd(4'h8, v); chk(v == 8'(4 - p), "R10 not counted before third edge", v, 4 - p);
      pulse_in = 1'b1;
      step(3);
      if (p < 3) begin
        chk(t2_flag == 0, "R10 flag before last edge", t2_flag, 0);
        rd(4'h8, v); chk(v == 8'(3 - p), "R10 counted once", v, 3 - p);
      end else begin
        chk(t2_flag == 1, "R10 flag on last edge", t2_flag, 1);
        rd(4'h8, v); chk(v == 0, "R10 zero", v, 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule